// File: doc/BRIEF.md
# Memory-Mapped Interrupt Aggregator

This block gathers a bank of peripheral interrupt lines into sticky per-source pending flags. It combines them into one level interrupt toward a parent controller. Each input is synchronized into the block clock domain. A high synchronized input sets its pending flag. The flag stays set until software clears it through a level-held clear register.

Software sees three 32-bit registers on a simple strobe-based bus. The mask register is read/write, and a 1 in it blocks the corresponding source. The clear register is read/write: writing a bit to 1 and then back to 0 empties that source's pending flag. The status register is read-only and shows the pending flags that the mask lets through. The combined output is the registered OR of the status bits.

Software typically reads status and picks a set bit to service. It pulses that bit's clear field high then low, and repeats while bits remain.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the mask register (offset 0x14) reads 0xFFFFFFFF, the clear register (offset 0x10) and the status register (offset 0x1c) read 0, and `irq_o` is 0.
- R2: The mask register at byte offset 0x14 stores every written bit and returns the stored value on read.
- R3: The clear register at byte offset 0x10 stores every written bit, returns it on read, and holds it until the next write.
- R4: A source input held high sets its pending flag; the flag appears in status three clock edges after the input is first sampled high (two synchronizer stages plus the pending register). It stays set after the input falls, until cleared.
- R5: While clear bit n is 1, pending flag n is 0 and cannot be set even with input n high. Once the bit returns to 0, a still-high input sets the flag again.
- R6: Reading offset 0x1c returns pending AND NOT mask, bit n for source n; several bits can be set at once, and a mask bit of 1 hides its source.
- R7: `irq_o` equals the OR of all status bits one clock edge later.
- R8: Reads of any offset other than 0x10, 0x14 and 0x1c return 0. Writes to 0x1c or to unmapped offsets change no register.
- R9: `rdata_o` is loaded on the clock edge that samples `rd_i` high and holds its value while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Asynchronous peripheral interrupt lines, bit n is source n |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined level interrupt to the parent controller |

## Verification
The assertions check several rules on every cycle. A set clear bit forces its pending flag low on the next edge. Pending flags never drop without a clear bit. A flag rises only where the synchronized input was high. `irq_o` tracks the OR of the unmasked pending flags with one cycle of delay. Writes to the status offset leave the stored registers untouched, and read data holds between read strobes. Some behaviours show only in the bench's scenarios: the exact three-edge latency from an input to status, re-arming after a clear is released while the input stays high, several sources pending at once, and the read-back values of each offset.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h1c;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] d_i,
  output logic [N_SRC-1:0] q_o
);
  logic [N_SRC-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_agg_pending.sv
module irq_agg_pending #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hit_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[i] <= 1'b0;
      else if (clr_i[i]) pend_o[i] <= 1'b0;   // clear dominates set
      else if (hit_i[i]) pend_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  stat_i,
  output logic [N_SRC-1:0]  mask_o,
  output logic [N_SRC-1:0]  clr_o,
  output logic [N_SRC-1:0]  rdata_o
);
  logic [N_SRC-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      clr_o  <= '0;
    end else if (wr_i) begin
      if (addr_i == OFF_MASK) mask_o <= wdata_i;
      if (addr_i == OFF_CLR)  clr_o  <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_CLR:  rd_mux = clr_o;
      OFF_MASK: rd_mux = mask_o;
      OFF_STAT: rd_mux = stat_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] sync_q, pend_q, mask_q, clr_q, stat;

  irq_agg_sync #(.N_SRC(N_SRC), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(src_i), .q_o(sync_q)
  );

  irq_agg_pending #(.N_SRC(N_SRC)) u_pend (
    .clk_i, .rst_ni, .hit_i(sync_q), .clr_i(clr_q), .pend_o(pend_q)
  );

  irq_agg_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .stat_i(stat), .mask_o(mask_q), .clr_o(clr_q), .rdata_o
  );

  assign stat = pend_q & ~mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |stat;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_SRC-1:0]  rdata_o,
  input logic              irq_o,
  input logic [N_SRC-1:0]  sync_q,
  input logic [N_SRC-1:0]  pend_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  clr_q
);
  a_r5_clear_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & $past(clr_q)) == '0);

  a_r4_pending_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q) & ~$past(clr_q) & ~pend_q) == '0);

  a_r4_set_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~$past(pend_q) & ~$past(sync_q)) == '0);

  a_r7_irq_tracks_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(pend_q & ~mask_q)));

  a_r8_status_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_STAT) |=> ($stable(mask_q) && $stable(clr_q)));

  a_r9_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind irq_agg_top irq_agg_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .rdata_o, .irq_o,
  .sync_q, .pend_q, .mask_q, .clr_q
);

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_agg_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {req[76:73], wr[72], addr[71:64], data[63:32], exp[31:0]}
  localparam logic [76:0] TBL [16] = '{
    {4'd1, 1'b0, 8'h14, 32'h0, 32'hFFFF_FFFF},       // R1
    {4'd1, 1'b0, 8'h10, 32'h0, 32'h0},               // R1
    {4'd1, 1'b0, 8'h1c, 32'h0, 32'h0},               // R1
    {4'd2, 1'b1, 8'h14, 32'hA5A5_0F0F, 32'h0},       // R2
    {4'd2, 1'b0, 8'h14, 32'h0, 32'hA5A5_0F0F},
    {4'd3, 1'b1, 8'h10, 32'h1234_5678, 32'h0},       // R3
    {4'd3, 1'b0, 8'h10, 32'h0, 32'h1234_5678},
    {4'd3, 1'b1, 8'h10, 32'h0, 32'h0},
    {4'd3, 1'b0, 8'h10, 32'h0, 32'h0},
    {4'd8, 1'b1, 8'h1c, 32'hFFFF_FFFF, 32'h0},       // R8
    {4'd8, 1'b0, 8'h14, 32'h0, 32'hA5A5_0F0F},
    {4'd8, 1'b0, 8'h10, 32'h0, 32'h0},
    {4'd8, 1'b1, 8'h04, 32'hDEAD_BEEF, 32'h0},
    {4'd8, 1'b0, 8'h04, 32'h0, 32'h0},
    {4'd8, 1'b0, 8'h14, 32'h0, 32'hA5A5_0F0F},
    {4'd8, 1'b0, 8'h18, 32'h0, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, held;
    idle(3);
    chk("R1 irq_o", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 irq_o after release", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 16; i++) begin
      if (TBL[i][72]) bus_wr(TBL[i][71:64], TBL[i][63:32]);
      else begin
        bus_rd(TBL[i][71:64], v);
        chk($sformatf("R%0d table[%0d]", TBL[i][76:73], i), v, TBL[i][31:0]);
      end
    end

    // R4/R7: latency of one source, then stickiness
    bus_wr(8'h14, 32'h0);
    idle(2);
    @(negedge clk); src[3] = 1'b1;
    idle(3);   // three edges: sync1, sync2, pending
    chk("R7 irq_o not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq_o asserted", {31'b0, irq}, 32'h1);
    src[3] = 1'b0;
    idle(5);
    bus_rd(8'h1c, v);
    chk("R4 sticky status", v, 32'h0000_0008);

    // R9: read data held without a read strobe
    held = rdata;
    src[0] = 1'b1;
    idle(4);
    chk("R9 rdata held", rdata, held);

    // R6: several bits, and masking hides a source
    src[31] = 1'b1;
    idle(4);
    src[31] = 1'b0;
    bus_rd(8'h1c, v);
    chk("R6 multi-bit status", v, 32'h8000_0009);
    bus_wr(8'h14, 32'h8000_0009);
    bus_rd(8'h1c, v);
    chk("R6 all masked", v, 32'h0);
    chk("R7 irq_o drops when masked", {31'b0, irq}, 32'h0);
    bus_wr(8'h14, 32'h0000_0008);
    bus_rd(8'h1c, v);
    chk("R6 partial mask", v, 32'h8000_0001);
    bus_wr(8'h14, 32'h0);

    // R5: clear holds pending low while src[0] stays high
    bus_wr(8'h10, 32'h0000_0009);
    idle(4);
    bus_rd(8'h1c, v);
    chk("R5 cleared while held", v, 32'h8000_0000);
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h1c, v);
    chk("R5 re-arms with input high", v, 32'h8000_0001);
    src[0] = 1'b0;
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_wr(8'h10, 32'h0);
    idle(3);
    bus_rd(8'h1c, v);
    chk("R5 all cleared", v, 32'h0);
    chk("R7 irq_o idle", {31'b0, irq}, 32'h0);

    finish_run();
  end
endmodule